// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drains a ring of transmit descriptors kept in a shared 16-bit buffer memory. The host fills buffers and descriptors, hands descriptors over by setting their ownership bit, and then pokes the block with a demand pulse. Once enabled, the block reads one descriptor after another. It checks that the descriptor is owned and well formed, and sends the buffer it points to as a byte stream with valid/ready handshaking. The stream marks the first byte and the last byte of each frame. A frame may be spread over several chained descriptors.

After a buffer has been sent, the block writes the descriptor back with ownership returned to the host. It then moves to the next ring slot, wrapping at the ring size. When the final byte of a frame is accepted, a one-cycle transmit interrupt pulse follows. A malformed descriptor stops the walk and raises a one-cycle fault pulse. The walk also stops at the first descriptor the host still owns, and after one full lap of the ring.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset the block is idle. `walk_busy`, `out_valid`, `mem_req`, `tx_int` and `tx_fault` are all low, and the ring index is 0.
- R2: A walk begins only while `tx_en` is high. A `tx_demand` pulse seen while disabled stays pending and starts a walk as soon as `tx_en` rises. The pending demand is consumed when the walk begins.
- R3: Descriptor i occupies four 16-bit words starting at byte address `ring_base + 8*i`. The buffer byte address is `{word1[7:0], word0}`. Buffer bytes are sent in ascending address order, and the even byte of each memory word is its low half (bits 7:0).
- R4: The buffer length is 4096 minus `word2[11:0]`. If `word2[15:12]` is not 4'hF, the walk stops silently: no bytes, no write-back, no fault.
- R5: The ownership bit is `word1[15]`. A descriptor whose ownership bit is clear stops the walk silently: no bytes, no write-back, no fault.
- R6: A buffer length below 12 or above 1900 stops the walk with a `tx_fault` pulse, no bytes and no write-back. Lengths of exactly 12 and 1900 are sent in full.
- R7: The start flag is `word1[9]` and the end flag is `word1[8]`. The first byte of a start descriptor carries `out_first`. The final byte of an end descriptor carries `out_last`. A frame chained over several descriptors has exactly one first marker and one last marker.
- R8: A descriptor without the start flag, arriving while no frame is open, stops the walk with a `tx_fault` pulse and no write-back.
- R9: A start descriptor arriving while a frame is still open abandons that frame (no `out_last` is sent for it) and opens a new frame whose first byte carries `out_first`.
- R10: After a descriptor's buffer has been sent, words 1 to 3 are written back. Word 1 has bit 15 cleared and its other bits unchanged. Words 2 and 3 are unchanged, and word 0 is not written.
- R11: The index wraps to 0 at the ring size `2**ring_len_code`, persists from one walk to the next, and the walk ends when the index returns to the value it had when the walk began.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_first` and `out_last` hold their values.
- R13: `tx_int` is high for exactly one cycle, the cycle after the handshake of a byte marked `out_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| tx_demand | input | 1 | Demand pulse requesting a ring walk |
| ring_base | input | ADDR_W | Byte address of descriptor 0 (bit 0 ignored) |
| ring_len_code | input | LEN_CODE_W | Ring size is 2 to this power |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | ADDR_W-1 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | First byte of a frame |
| out_last | output | 1 | Last byte of a frame |
| out_ready | input | 1 | Consumer accepts the byte |
| tx_int | output | 1 | One-cycle pulse at frame completion |
| tx_fault | output | 1 | One-cycle pulse on a malformed descriptor |
| walk_busy | output | 1 | Walk in progress |

## Verification
The bench builds the block with `ADDR_W` = 13 and the default 3-bit ring size code. The 13-bit address gives an 8 KiB memory that the bench fills completely with a known byte pattern. This leaves room for a full 1900-byte buffer next to the ring, and for buffers at odd byte addresses. Ring size codes of 1 and 2 keep wrap-around, the lap limit and index persistence across walks within a handful of descriptors. The consumer's ready signal is toggled irregularly to exercise the stall behaviour.

// File: rtl/tx_desc_ring.sv
module tx_desc_ring #(
  parameter int ADDR_W     = 24,
  parameter int LEN_CODE_W = 3,
  parameter int MIN_LEN    = 12,
  parameter int MAX_LEN    = 1900
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tx_en,
  input  logic                  tx_demand,
  input  logic [ADDR_W-1:0]     ring_base,
  input  logic [LEN_CODE_W-1:0] ring_len_code,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-2:0]     mem_addr,
  output logic [15:0]           mem_wdata,
  input  logic [15:0]           mem_rdata,
  output logic                  out_valid,
  output logic [7:0]            out_data,
  output logic                  out_first,
  output logic                  out_last,
  input  logic                  out_ready,
  output logic                  tx_int,
  output logic                  tx_fault,
  output logic                  walk_busy
);

  localparam int WA    = ADDR_W - 1;
  localparam int IDX_W = (1 << LEN_CODE_W) - 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_RD, S_LAT, S_OUT, S_WB} state_t;

  state_t            state;
  logic              pend;
  logic [IDX_W-1:0]  idx, start_idx;
  logic [2:0]        k;
  logic [15:0]       dw [4];
  logic              frame_open, first_pend;
  logic [ADDR_W-1:0] baddr;
  logic [11:0]       remain;
  logic [15:0]       wbuf;

  logic              own, stp, enp, mark_ok, len_ok, start_walk;
  logic [12:0]       blen;
  logic [IDX_W:0]    ring_size, nxt;
  logic [IDX_W-1:0]  nidx;
  logic [2:0]        off;
  logic              unused_bits;

  assign own     = dw[1][15];
  assign stp     = dw[1][9];
  assign enp     = dw[1][8];
  assign mark_ok = dw[2][15:12] == 4'hF;
  assign blen    = 13'h1000 - {1'b0, dw[2][11:0]};
  assign len_ok  = blen >= 13'(MIN_LEN) && blen <= 13'(MAX_LEN);

  assign ring_size = (IDX_W+1)'(1) << ring_len_code;
  assign nxt       = {1'b0, idx} + 1'b1;
  assign nidx      = (nxt == ring_size) ? '0 : nxt[IDX_W-1:0];

  assign start_walk = state == S_IDLE && tx_en && (pend || tx_demand);

  assign off       = (state == S_WB) ? k + 3'd1 : k;
  assign mem_req   = (state == S_FETCH && k < 3'd4) || state == S_RD || state == S_WB;
  assign mem_we    = state == S_WB;
  assign mem_addr  = (state == S_RD) ? baddr[ADDR_W-1:1]
                   : ring_base[ADDR_W-1:1] + (WA'(idx) << 2) + WA'(off);
  assign mem_wdata = (k == 3'd0) ? (dw[1] & 16'h7FFF) : (k == 3'd1) ? dw[2] : dw[3];

  assign out_valid = state == S_OUT;
  assign out_data  = baddr[0] ? wbuf[15:8] : wbuf[7:0];
  assign out_first = first_pend;
  assign out_last  = enp && remain == 12'd1;
  assign walk_busy = state != S_IDLE;

  assign unused_bits = ^{ring_base[0], blen[12]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      pend       <= 1'b0;
      idx        <= '0;
      start_idx  <= '0;
      k          <= '0;
      for (int i = 0; i < 4; i++) dw[i] <= '0;
      frame_open <= 1'b0;
      first_pend <= 1'b0;
      baddr      <= '0;
      remain     <= '0;
      wbuf       <= '0;
      tx_int     <= 1'b0;
      tx_fault   <= 1'b0;
    end else begin
      tx_int   <= 1'b0;
      tx_fault <= 1'b0;
      pend     <= (pend || tx_demand) && !start_walk;
      case (state)
        S_IDLE: if (start_walk) begin
          start_idx <= idx;
          k         <= '0;
          state     <= S_FETCH;
        end
        S_FETCH: begin
          k <= k + 3'd1;
          if (k != 3'd0) dw[2'(k - 3'd1)] <= mem_rdata;
          if (k == 3'd4) state <= S_CHECK;
        end
        S_CHECK: begin
          if (!own || !mark_ok) begin
            state <= S_IDLE;
          end else if (!len_ok || (!stp && !frame_open)) begin
            tx_fault <= 1'b1;
            state    <= S_IDLE;
          end else begin
            baddr  <= ADDR_W'({dw[1][7:0], dw[0]});
            remain <= blen[11:0];
            if (stp) begin
              frame_open <= 1'b1;
              first_pend <= 1'b1;
            end
            state <= S_RD;
          end
        end
        S_RD:  state <= S_LAT;
        S_LAT: begin
          wbuf  <= mem_rdata;
          state <= S_OUT;
        end
        S_OUT: if (out_ready) begin
          first_pend <= 1'b0;
          baddr      <= baddr + 1'b1;
          remain     <= remain - 12'd1;
          if (remain == 12'd1) begin
            if (enp) begin
              frame_open <= 1'b0;
              tx_int     <= 1'b1;
            end
            k     <= '0;
            state <= S_WB;
          end else if (!baddr[0]) begin
            state <= S_OUT;
          end else begin
            state <= S_RD;
          end
        end
        S_WB: begin
          k <= k + 3'd1;
          if (k == 3'd2) begin
            idx <= nidx;
            k   <= '0;
            state <= (nidx == start_idx) ? S_IDLE : S_FETCH;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_busy |-> !mem_req && !out_valid); // R2
  AST_NO_MEM_IN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !mem_req); // R3
  AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fault |-> !mem_we && !out_valid); // R6
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid); // R7
  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    walk_busy |-> {1'b0, idx} < ring_size); // R11
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last)); // R12
  AST_INT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_int |-> $past(out_valid && out_ready && out_last)); // R13
  AST_INT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_int |=> !tx_int); // R13

endmodule

// File: tb/test_tx_desc_ring.sv
module test_tx_desc_ring;
  localparam int AW = 13;
  localparam int RB = 16'h0100;
  localparam int RBW = RB / 2;
  localparam logic [7:0] F_OWN = 8'h80, F_STP = 8'h02, F_ENP = 8'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, tx_demand = 1'b0;
  logic [AW-1:0] ring_base = AW'(RB);
  logic [2:0] ring_len_code = 3'd1;
  logic mem_req, mem_we;
  logic [AW-2:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic out_valid, out_first, out_last, tx_int, tx_fault, walk_busy;
  logic [7:0] out_data;
  logic out_ready = 1'b1;

  logic [15:0] mem [0:4095];
  logic bd_we = 1'b0;
  logic [11:0] bd_addr = '0;
  logic [15:0] bd_data = '0;

  int checks = 0, errors = 0;
  logic clr = 1'b0;
  logic rdy_mode = 1'b0;
  int cyc = 0;

  logic [7:0] bq [0:2047];
  logic fq [0:2047];
  logic lq [0:2047];
  int nbytes, nwr, nint, nfault, nstall;
  logic prev_stall = 1'b0;
  logic [9:0] prev_out = '0;

  always #2 clk = ~clk;

  tx_desc_ring #(.ADDR_W(AW)) i_tx_desc_ring (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_demand(tx_demand),
    .ring_base(ring_base), .ring_len_code(ring_len_code),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first),
    .out_last(out_last), .out_ready(out_ready),
    .tx_int(tx_int), .tx_fault(tx_fault), .walk_busy(walk_busy));

  always @(posedge clk) begin
    if (bd_we) mem[bd_addr] <= bd_data;
    else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (clr) begin
      nbytes <= 0; nwr <= 0; nint <= 0; nfault <= 0; nstall <= 0;
    end else begin
      if (out_valid && out_ready && nbytes < 2048) begin
        bq[nbytes] <= out_data; fq[nbytes] <= out_first; lq[nbytes] <= out_last;
        nbytes <= nbytes + 1;
      end
      if (mem_req && mem_we) nwr <= nwr + 1;
      if (tx_int) nint <= nint + 1;
      if (tx_fault) nfault <= nfault + 1;
      if (prev_stall && !(out_valid && {out_data, out_first, out_last} == prev_out)) nstall <= nstall + 1;
    end
    prev_stall <= out_valid && !out_ready;
    prev_out <= {out_data, out_first, out_last};
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= rdy_mode ? (cyc[0] ^ cyc[2]) | cyc[3] & cyc[1] : 1'b1;
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] v);
    @(negedge clk); bd_we = 1'b1; bd_addr = 12'(a); bd_data = v;
    @(negedge clk); bd_we = 1'b0;
  endtask

  task automatic put_desc(input int i, input int baddr, input logic [7:0] fl, input int len, input logic [15:0] w3);
    wr(RBW + 4*i + 0, 16'(baddr));
    wr(RBW + 4*i + 1, {fl, 8'h00});
    wr(RBW + 4*i + 2, 16'hF000 | 16'((4096 - len) & 12'hFFF));
    wr(RBW + 4*i + 3, w3);
  endtask

  task automatic clear_mon();
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; clr = 1'b0;
  endtask

  task automatic run_walk();
    @(negedge clk); tx_demand = 1'b1;
    @(negedge clk); tx_demand = 1'b0;
    repeat (3) @(negedge clk);
    while (walk_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_bytes(input string req, input int pos, input int addr, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (bq[pos+i] !== pat(addr+i)) bad++;
    chk(req, "payload mismatches", bad, 0);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1", "busy/valid/req/int/fault", {walk_busy, out_valid, mem_req, tx_int, tx_fault}, 0);
  endtask

  task automatic t_single();
    int fc = 0, lc = 0;
    do_reset(); tx_en = 1'b1; ring_len_code = 3'd1; rdy_mode = 1'b0;
    put_desc(0, 16'h0401, F_OWN | F_STP | F_ENP, 12, 16'h1234);
    put_desc(1, 16'h0500, F_STP | F_ENP, 12, 16'h0);
    clear_mon();
    run_walk();
    chk("R3", "byte count", nbytes, 12);
    chk_bytes("R3", 0, 16'h0401, 12);
    for (int i = 0; i < 12; i++) begin fc += int'(fq[i]); lc += int'(lq[i]); end
    chk("R7", "first on byte 0", int'(fq[0]), 1);
    chk("R7", "last on byte 11", int'(lq[11]), 1);
    chk("R7", "marker totals", fc + lc, 2);
    chk("R10", "word1 written back", mem[RBW+1], 16'h0300);
    chk("R10", "word2 written back", mem[RBW+2], 16'hFFF4);
    chk("R10", "word3 written back", mem[RBW+3], 16'h1234);
    chk("R10", "word0 untouched", mem[RBW+0], 16'h0401);
    chk("R10", "write count", nwr, 3);
    chk("R13", "interrupt pulses", nint, 1);
    chk("R5", "stopped at host-owned desc", int'(mem[RBW+5]), 16'h0300);
  endtask

  task automatic t_chain();
    int fc = 0, lc = 0;
    do_reset(); tx_en = 1'b1; ring_len_code = 3'd2; rdy_mode = 1'b1;
    put_desc(0, 16'h0600, F_OWN | F_STP, 12, 16'h0);
    put_desc(1, 16'h0641, F_OWN, 13, 16'h0);
    put_desc(2, 16'h0680, F_OWN | F_ENP, 14, 16'h0);
    put_desc(3, 16'h06C0, 8'h00, 12, 16'h0);
    clear_mon();
    run_walk();
    rdy_mode = 1'b0;
    chk("R7", "chained byte count", nbytes, 39);
    chk_bytes("R7", 0, 16'h0600, 12);
    chk_bytes("R7", 12, 16'h0641, 13);
    chk_bytes("R7", 25, 16'h0680, 14);
    for (int i = 0; i < 39; i++) begin fc += int'(fq[i]); lc += int'(lq[i]); end
    chk("R7", "single first marker", fc, 1);
    chk("R7", "single last marker at end", lc + int'(lq[38]), 2);
    chk("R12", "stall hold violations", nstall, 0);
    chk("R13", "one interrupt for chain", nint, 1);
  endtask

  task automatic t_own_mark();
    do_reset(); tx_en = 1'b1; ring_len_code = 3'd1;
    put_desc(0, 16'h0400, F_STP | F_ENP, 12, 16'h0);
    clear_mon(); run_walk();
    chk("R5", "not owned: bytes+writes+fault", nbytes + nwr + nfault, 0);
    put_desc(0, 16'h0400, F_OWN | F_STP | F_ENP, 20, 16'h0);
    wr(RBW + 2, 16'hEFEC);
    clear_mon(); run_walk();
    chk("R4", "bad marker: bytes+writes+fault", nbytes + nwr + nfault, 0);
    wr(RBW + 2, 16'hFFEC);
    clear_mon(); run_walk();
    chk("R4", "length 20 from two's complement", nbytes, 20);
    chk_bytes("R4", 0, 16'h0400, 20);
  endtask

  task automatic t_len_bounds();
    do_reset(); tx_en = 1'b1; ring_len_code = 3'd1;
    put_desc(0, 16'h0400, F_OWN | F_STP | F_ENP, 11, 16'h0);
    clear_mon(); run_walk();
    chk("R6", "len 11 fault", nfault, 1);
    chk("R6", "len 11 bytes+writes", nbytes + nwr, 0);
    put_desc(0, 16'h0400, F_OWN | F_STP | F_ENP, 1901, 16'h0);
    clear_mon(); run_walk();
    chk("R6", "len 1901 fault", nfault, 1);
    chk("R6", "len 1901 bytes+writes", nbytes + nwr, 0);
    put_desc(0, 16'h0800, F_OWN | F_STP | F_ENP, 1900, 16'h0);
    clear_mon(); run_walk();
    chk("R6", "len 1900 byte count", nbytes, 1900);
    chk("R6", "len 1900 last marker", int'(lq[1899]), 1);
    chk_bytes("R6", 0, 16'h0800, 1900);
    chk("R6", "len 1900 no fault", nfault, 0);
  endtask

  task automatic t_orphan();
    do_reset(); tx_en = 1'b1; ring_len_code = 3'd1;
    put_desc(0, 16'h0400, F_OWN | F_ENP, 12, 16'h0);
    clear_mon(); run_walk();
    chk("R8", "orphan continuation fault", nfault, 1);
    chk("R8", "orphan bytes+writes", nbytes + nwr, 0);
    chk("R8", "orphan desc still owned", int'(mem[RBW+1]), 16'h8100);
  endtask

  task automatic t_restart();
    int lc = 0;
    do_reset(); tx_en = 1'b1; ring_len_code = 3'd2;
    put_desc(0, 16'h0400, F_OWN | F_STP, 12, 16'h0);
    put_desc(1, 16'h0480, F_OWN | F_STP | F_ENP, 12, 16'h0);
    put_desc(2, 16'h0500, 8'h00, 12, 16'h0);
    clear_mon(); run_walk();
    chk("R9", "byte count", nbytes, 24);
    chk("R9", "new first marker", int'(fq[12]), 1);
    for (int i = 0; i < 24; i++) lc += int'(lq[i]);
    chk("R9", "only one last marker", lc, 1);
    chk_bytes("R9", 12, 16'h0480, 12);
    chk("R9", "one interrupt", nint, 1);
  endtask

  task automatic t_wrap();
    do_reset(); tx_en = 1'b1; ring_len_code = 3'd2;
    put_desc(0, 16'h0400, F_OWN | F_STP | F_ENP, 12, 16'h0);
    put_desc(1, 16'h0440, 8'h00, 12, 16'h0);
    clear_mon(); run_walk();
    chk("R11", "first walk bytes", nbytes, 12);
    put_desc(1, 16'h0500, F_OWN | F_STP | F_ENP, 12, 16'h0);
    put_desc(2, 16'h0540, F_OWN | F_STP | F_ENP, 12, 16'h0);
    put_desc(3, 16'h0580, F_OWN | F_STP | F_ENP, 12, 16'h0);
    put_desc(0, 16'h05C0, F_OWN | F_STP | F_ENP, 12, 16'h0);
    put_desc(4, 16'h0700, F_OWN | F_STP | F_ENP, 12, 16'h0);
    clear_mon(); run_walk();
    chk("R11", "lap byte count", nbytes, 48);
    chk_bytes("R11", 0, 16'h0500, 12);
    chk_bytes("R11", 12, 16'h0540, 12);
    chk_bytes("R11", 24, 16'h0580, 12);
    chk_bytes("R11", 36, 16'h05C0, 12);
    chk("R11", "slot beyond ring untouched", int'(mem[RBW+17]), 16'h8300);
    chk("R11", "lap writes", nwr, 12);
    chk("R13", "lap interrupts", nint, 4);
  endtask

  task automatic t_enable();
    do_reset(); tx_en = 1'b0; ring_len_code = 3'd1;
    put_desc(0, 16'h0400, F_OWN | F_STP | F_ENP, 12, 16'h0);
    clear_mon();
    @(negedge clk); tx_demand = 1'b1; @(negedge clk); tx_demand = 1'b0;
    repeat (10) @(negedge clk);
    chk("R2", "disabled: busy+bytes", int'(walk_busy) + nbytes + nwr, 0);
    tx_en = 1'b1;
    repeat (3) @(negedge clk);
    while (walk_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2", "pending demand served", nbytes, 12);
    put_desc(1, 16'h0440, F_OWN | F_STP | F_ENP, 12, 16'h0);
    clear_mon();
    repeat (10) @(negedge clk);
    chk("R2", "demand consumed", nbytes, 0);
  endtask

  initial begin
    for (int w = 0; w < 4096; w++) begin
      @(negedge clk); bd_we = 1'b1; bd_addr = 12'(w); bd_data = {pat(2*w+1), pat(2*w)};
    end
    @(negedge clk); bd_we = 1'b0;
    t_reset();
    t_single();
    t_chain();
    t_own_mark();
    t_len_bounds();
    t_orphan();
    t_restart();
    t_wrap();
    t_enable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
    $finish;
  end
endmodule